// File: doc/BRIEF.md
# Memory-Mapped Peripheral Port Hub

This block sits between a processor's I/O bus and a handful of board peripherals. The processor drives an address, a write-data word and a one-cycle write strobe. Any address above the 64 KiB memory window (0x0000_0000 to 0x0000_FFFF, 16 Ki 32-bit words, with the stack at its top) is treated as a peripheral port. Addresses inside the window belong to memory, and this block ignores them.

Three output ports hold state in registers: 16 LED lines, 8 segment lines and 4 digit-enable lines, 28 flip-flops in all. Each register loads on a rising clock edge when the strobe is high and the address equals that port's address. The input ports carry 16 switches and a small group of buttons. These are not registered: they pass through a combinational multiplexer onto the read-data bus in the same cycle as the address. Reads and writes are decoded by separate hardware. One port address can therefore act as a registered output and an unregistered input at the same time.

Top module: `mmio_port_hub`

## Requirements
- R1: While `rst_n` is low at a rising edge, the registers reset on that edge. `led_out` becomes 0x0000. `seg_out` becomes 0xFF and `an_out` becomes 0xF, which is all dark because both are active-low.
- R2: With `bus_wr_en` high and `bus_addr` = 0x1100_0020 at a rising edge, `led_out` takes `bus_wdata[15:0]` on that edge.
- R3: With `bus_wr_en` high and `bus_addr` = 0x1100_0040 at a rising edge, `seg_out` takes `bus_wdata[7:0]` on that edge.
- R4: With `bus_wr_en` high and `bus_addr` = 0x1100_0044 at a rising edge, `an_out` takes `bus_wdata[3:0]` on that edge.
- R5: While `bus_wr_en` is low, no output register changes, even when the address matches an output port.
- R6: A write to any address at or below 0x0000_FFFF leaves all output registers unchanged. This includes addresses whose low bits equal a port offset.
- R7: A write to an I/O address that is not an output port is ignored. Examples are 0x1100_0030, 0x0001_0000, and the input addresses.
- R8: While `bus_addr` = 0x1100_0000, `bus_rdata` equals `{16'h0, sw_in}` in the same cycle, with no clock edge needed.
- R9: While `bus_addr` = 0x1100_0004, `bus_rdata` equals `btn_in` zero-extended to 32 bits, in the same cycle.
- R10: For any address that is not an input port, `bus_rdata` is 0x0000_0000. This covers memory addresses and output-only ports.
- R11: When an input port's address parameter is set equal to an output port's address, a write to that address loads the output register. In the same cycles, `bus_rdata` still returns the input value.
- R12: A write to one output port leaves the other two output registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 32 | Processor I/O address |
| bus_wdata | input | 32 | Processor write data |
| bus_wr_en | input | 1 | Write strobe for the current access |
| sw_in | input | 16 | Switch levels |
| btn_in | input | 2 | Button levels |
| bus_rdata | output | 32 | Combinational read data to the processor |
| led_out | output | 16 | LED register |
| seg_out | output | 8 | Segment register, active low |
| an_out | output | 4 | Digit-enable register, active low |

## Verification
The bound checker watches every cycle. It checks that each strobed write to an output port lands in that port's register on the next edge, and that the other registers stay put. It also checks that unstrobed, memory-range and unmapped writes change nothing, and that the read bus always reflects the selected input or zero. The bench's own scenarios cover the rest. These are the reset values seen at the pins, writes whose low address bits alias a port inside memory, and returning to reset mid-run. The bench also builds a second instance whose switch port shares the LED address, to show a simultaneous read and write at one address.

// File: rtl/mmio_pkg.sv
// Package of shared constants for the peripheral port hub.
// Assumes a 32-bit I/O bus; the port index order below is used by the decoder.
package mmio_pkg;
    localparam int BUS_W = 32;

    // Index of each output port in the decoder's write-select vector.
    typedef enum int {
        OPORT_LED = 0,
        OPORT_SEG = 1,
        OPORT_AN  = 2
    } oport_e;
    localparam int N_OPORT = 3;

    // Index of each input port in the decoder's read-select vector.
    typedef enum int {
        IPORT_SW  = 0,
        IPORT_BTN = 1
    } iport_e;
    localparam int N_IPORT = 2;
endpackage

// File: rtl/mmio_addr_decode.sv
// Address decoder: compares the bus address against each port address.
// Assumes memory owns every address at or below MEM_TOP; ports live above it.
// Write and read selects are produced by independent compare banks.
module mmio_addr_decode #(
    parameter int                          ADDR_W    = 32,
    parameter int                          N_WR      = 3,
    parameter int                          N_RD      = 2,
    parameter logic [ADDR_W-1:0]           MEM_TOP   = 32'h0000_FFFF,
    parameter logic [N_WR*ADDR_W-1:0]      WR_ADDRS  = '0,
    parameter logic [N_RD*ADDR_W-1:0]      RD_ADDRS  = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    output logic [N_WR-1:0]   wr_sel,
    output logic [N_RD-1:0]   rd_sel
);
    logic in_io_space;

    // Qualify every select with the I/O-space test.
    assign in_io_space = (addr > MEM_TOP);

    genvar gi;
    generate
        for (gi = 0; gi < N_WR; gi++) begin : g_wr
            // One write strobe per output port: strobe, space and exact match.
            assign wr_sel[gi] = wr_en && in_io_space &&
                                (addr == WR_ADDRS[gi*ADDR_W +: ADDR_W]);
        end
        for (gi = 0; gi < N_RD; gi++) begin : g_rd
            // One read select per input port, independent of the strobe.
            assign rd_sel[gi] = in_io_space &&
                                (addr == RD_ADDRS[gi*ADDR_W +: ADDR_W]);
        end
    endgenerate
endmodule

// File: rtl/mmio_out_reg.sv
// Output port register: loads on a strobed edge, holds otherwise.
// Assumes a synchronous active-low reset to a per-port value.
module mmio_out_reg #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Hold state; reset has priority over a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/mmio_read_mux.sv
// Read multiplexer: AND-OR of input words under one-hot-or-zero selects.
// Assumes selects are mutually exclusive; no select gives an all-zero word.
module mmio_read_mux #(
    parameter int N_SRC  = 2,
    parameter int DATA_W = 32
) (
    input  logic [N_SRC-1:0]        sel,
    input  logic [N_SRC*DATA_W-1:0] src,
    output logic [DATA_W-1:0]       dout
);
    // Combine the gated sources; nothing is registered on the read path.
    always_comb begin
        dout = '0;
        for (int k = 0; k < N_SRC; k++) begin
            dout = dout | (src[k*DATA_W +: DATA_W] & {DATA_W{sel[k]}});
        end
    end
endmodule

// File: rtl/mmio_port_hub.sv
// Peripheral port hub: decodes I/O addresses, latches output ports on
// strobed writes and returns input ports through an unregistered mux.
// Assumes addresses above MEM_TOP are I/O and that port widths fit the bus.
module mmio_port_hub
    import mmio_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = BUS_W,
    parameter logic [ADDR_W-1:0] MEM_TOP  = 32'h0000_FFFF,
    parameter int                LED_W    = 16,
    parameter int                SEG_W    = 8,
    parameter int                AN_W     = 4,
    parameter int                SW_W     = 16,
    parameter int                BTN_W    = 2,
    parameter logic [ADDR_W-1:0] LED_ADDR = 32'h1100_0020,
    parameter logic [ADDR_W-1:0] SEG_ADDR = 32'h1100_0040,
    parameter logic [ADDR_W-1:0] AN_ADDR  = 32'h1100_0044,
    parameter logic [ADDR_W-1:0] SW_ADDR  = 32'h1100_0000,
    parameter logic [ADDR_W-1:0] BTN_ADDR = 32'h1100_0004,
    parameter logic [SEG_W-1:0]  SEG_RST  = '1,
    parameter logic [AN_W-1:0]   AN_RST   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr_en,
    input  logic [SW_W-1:0]   sw_in,
    input  logic [BTN_W-1:0]  btn_in,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [LED_W-1:0]  led_out,
    output logic [SEG_W-1:0]  seg_out,
    output logic [AN_W-1:0]   an_out
);
    localparam logic [N_OPORT*ADDR_W-1:0] WR_MAP = {AN_ADDR, SEG_ADDR, LED_ADDR};
    localparam logic [N_IPORT*ADDR_W-1:0] RD_MAP = {BTN_ADDR, SW_ADDR};

    logic [N_OPORT-1:0]        wr_sel;
    logic [N_IPORT-1:0]        rd_sel;
    logic [N_IPORT*DATA_W-1:0] rd_src;
    logic                      unused_wdata_hi;

    // Upper write-data bits have no destination in any port.
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:LED_W];

    mmio_addr_decode #(
        .ADDR_W   (ADDR_W),
        .N_WR     (N_OPORT),
        .N_RD     (N_IPORT),
        .MEM_TOP  (MEM_TOP),
        .WR_ADDRS (WR_MAP),
        .RD_ADDRS (RD_MAP)
    ) u_decode (
        .addr   (bus_addr),
        .wr_en  (bus_wr_en),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    mmio_out_reg #(.W(LED_W), .RST_VAL('0)) u_led_reg (
        .clk (clk), .rst_n (rst_n), .load (wr_sel[OPORT_LED]),
        .d (bus_wdata[LED_W-1:0]), .q (led_out)
    );

    mmio_out_reg #(.W(SEG_W), .RST_VAL(SEG_RST)) u_seg_reg (
        .clk (clk), .rst_n (rst_n), .load (wr_sel[OPORT_SEG]),
        .d (bus_wdata[SEG_W-1:0]), .q (seg_out)
    );

    mmio_out_reg #(.W(AN_W), .RST_VAL(AN_RST)) u_an_reg (
        .clk (clk), .rst_n (rst_n), .load (wr_sel[OPORT_AN]),
        .d (bus_wdata[AN_W-1:0]), .q (an_out)
    );

    // Zero-extend each input group to a bus word in select order.
    assign rd_src = {{(DATA_W-BTN_W){1'b0}}, btn_in,
                     {(DATA_W-SW_W){1'b0}},  sw_in};

    mmio_read_mux #(.N_SRC(N_IPORT), .DATA_W(DATA_W)) u_rmux (
        .sel  (rd_sel),
        .src  (rd_src),
        .dout (bus_rdata)
    );
endmodule

// File: rtl/mmio_port_hub_chk.sv
// Checker for the peripheral port hub, observing only its ports.
// Assumes the default port map has distinct addresses for every port.
module mmio_port_hub_chk #(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter logic [ADDR_W-1:0] MEM_TOP  = 32'h0000_FFFF,
    parameter int                LED_W    = 16,
    parameter int                SEG_W    = 8,
    parameter int                AN_W     = 4,
    parameter int                SW_W     = 16,
    parameter int                BTN_W    = 2,
    parameter logic [ADDR_W-1:0] LED_ADDR = 32'h1100_0020,
    parameter logic [ADDR_W-1:0] SEG_ADDR = 32'h1100_0040,
    parameter logic [ADDR_W-1:0] AN_ADDR  = 32'h1100_0044,
    parameter logic [ADDR_W-1:0] SW_ADDR  = 32'h1100_0000,
    parameter logic [ADDR_W-1:0] BTN_ADDR = 32'h1100_0004,
    parameter logic [SEG_W-1:0]  SEG_RST  = '1,
    parameter logic [AN_W-1:0]   AN_RST   = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_wr_en,
    input logic [SW_W-1:0]   sw_in,
    input logic [BTN_W-1:0]  btn_in,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LED_W-1:0]  led_out,
    input logic [SEG_W-1:0]  seg_out,
    input logic [AN_W-1:0]   an_out
);
    logic hit_out;
    logic hit_in;

    // Port-map membership as seen from the outside.
    assign hit_out = (bus_addr == LED_ADDR) || (bus_addr == SEG_ADDR) ||
                     (bus_addr == AN_ADDR);
    assign hit_in  = (bus_addr == SW_ADDR) || (bus_addr == BTN_ADDR);

    assert_reset_vals_R1: assert property (@(posedge clk)
        !rst_n |=> (led_out == '0 && seg_out == SEG_RST && an_out == AN_RST));

    assert_led_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == LED_ADDR) |=> led_out == $past(bus_wdata[LED_W-1:0]));

    assert_seg_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == SEG_ADDR) |=> seg_out == $past(bus_wdata[SEG_W-1:0]));

    assert_an_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == AN_ADDR) |=> an_out == $past(bus_wdata[AN_W-1:0]));

    assert_no_strobe_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_en |=> ($stable(led_out) && $stable(seg_out) && $stable(an_out)));

    assert_mem_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr <= MEM_TOP) |=> ($stable(led_out) && $stable(seg_out) && $stable(an_out)));

    assert_unmapped_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > MEM_TOP && !hit_out) |=>
        ($stable(led_out) && $stable(seg_out) && $stable(an_out)));

    assert_switch_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SW_ADDR) |-> bus_rdata == DATA_W'(sw_in));

    assert_button_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == BTN_ADDR && bus_addr != SW_ADDR) |-> bus_rdata == DATA_W'(btn_in));

    assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_in |-> bus_rdata == '0);

    assert_led_write_isolated_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == LED_ADDR && bus_addr != SEG_ADDR && bus_addr != AN_ADDR)
        |=> ($stable(seg_out) && $stable(an_out)));
endmodule

bind mmio_port_hub mmio_port_hub_chk #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .MEM_TOP (MEM_TOP),
    .LED_W (LED_W), .SEG_W (SEG_W), .AN_W (AN_W), .SW_W (SW_W), .BTN_W (BTN_W),
    .LED_ADDR (LED_ADDR), .SEG_ADDR (SEG_ADDR), .AN_ADDR (AN_ADDR),
    .SW_ADDR (SW_ADDR), .BTN_ADDR (BTN_ADDR),
    .SEG_RST (SEG_RST), .AN_RST (AN_RST)
) u_chk (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_wr_en (bus_wr_en), .sw_in (sw_in), .btn_in (btn_in),
    .bus_rdata (bus_rdata), .led_out (led_out), .seg_out (seg_out), .an_out (an_out)
);

// File: tb/mmio_port_hub_tb.sv
// Bench for the peripheral port hub: a vector table, then directed tests
// for reset and for a shared read/write address.
module mmio_port_hub_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        we;
        logic [15:0] sw;
        logic [1:0]  btn;
        logic [15:0] e_led;
        logic [7:0]  e_seg;
        logic [3:0]  e_an;
        logic [31:0] e_rd;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{8'd2,  32'h1100_0020, 32'hA5A5_1234, 1'b1, 16'h0000, 2'b00, 16'h1234, 8'hFF, 4'hF, 32'h0},  // R2
        '{8'd3,  32'h1100_0040, 32'h0000_0081, 1'b1, 16'h0000, 2'b00, 16'h1234, 8'h81, 4'hF, 32'h0},  // R3
        '{8'd4,  32'h1100_0044, 32'hFFFF_FFF6, 1'b1, 16'h0000, 2'b00, 16'h1234, 8'h81, 4'h6, 32'h0},  // R4
        '{8'd5,  32'h1100_0020, 32'h0000_FFFF, 1'b0, 16'h0000, 2'b00, 16'h1234, 8'h81, 4'h6, 32'h0},  // R5
        '{8'd6,  32'h0000_0020, 32'h0000_BEEF, 1'b1, 16'h0000, 2'b00, 16'h1234, 8'h81, 4'h6, 32'h0},  // R6 alias
        '{8'd6,  32'h0000_FFFF, 32'h0000_BEEF, 1'b1, 16'h0000, 2'b00, 16'h1234, 8'h81, 4'h6, 32'h0},  // R6 top
        '{8'd6,  32'h0000_F000, 32'h0000_BEEF, 1'b1, 16'h0000, 2'b00, 16'h1234, 8'h81, 4'h6, 32'h0},  // R6 stack
        '{8'd7,  32'h1100_0030, 32'h0000_BEEF, 1'b1, 16'h0000, 2'b00, 16'h1234, 8'h81, 4'h6, 32'h0},  // R7
        '{8'd8,  32'h1100_0000, 32'h0000_5555, 1'b1, 16'hC3C3, 2'b00, 16'h1234, 8'h81, 4'h6, 32'h0000_C3C3}, // R8
        '{8'd9,  32'h1100_0004, 32'h0000_0000, 1'b0, 16'hC3C3, 2'b10, 16'h1234, 8'h81, 4'h6, 32'h0000_0002}, // R9
        '{8'd8,  32'h1100_0000, 32'h0000_0000, 1'b0, 16'h0001, 2'b11, 16'h1234, 8'h81, 4'h6, 32'h0000_0001}, // R8
        '{8'd12, 32'h1100_0020, 32'hFFFF_0000, 1'b1, 16'h0000, 2'b00, 16'h0000, 8'h81, 4'h6, 32'h0},  // R12
        '{8'd3,  32'h1100_0040, 32'h1234_5600, 1'b1, 16'h0000, 2'b00, 16'h0000, 8'h00, 4'h6, 32'h0},  // R3
        '{8'd7,  32'h0001_0000, 32'hFFFF_FFFF, 1'b1, 16'hFFFF, 2'b11, 16'h0000, 8'h00, 4'h6, 32'h0},  // R7 / R10
        '{8'd4,  32'h1100_0044, 32'h0000_0009, 1'b1, 16'h0000, 2'b00, 16'h0000, 8'h00, 4'h9, 32'h0}   // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr_en = 1'b0;
    logic [15:0] sw_in = '0;
    logic [1:0]  btn_in = '0;
    logic [31:0] bus_rdata, rdata2;
    logic [15:0] led_out, led2;
    logic [7:0]  seg_out, seg2;
    logic [3:0]  an_out, an2;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmio_port_hub u_dut (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_wr_en (bus_wr_en), .sw_in (sw_in), .btn_in (btn_in),
        .bus_rdata (bus_rdata), .led_out (led_out), .seg_out (seg_out), .an_out (an_out)
    );

    // Second instance: the switch port shares the LED address (R11).
    mmio_port_hub #(.SW_ADDR(32'h1100_0020)) u_dut_shared (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_wr_en (bus_wr_en), .sw_in (sw_in), .btn_in (btn_in),
        .bus_rdata (rdata2), .led_out (led2), .seg_out (seg2), .an_out (an2)
    );

    task automatic chk(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values at the pins
        chk(1, "led reset", 32'(led_out), 32'h0000);
        chk(1, "seg reset", 32'(seg_out), 32'hFF);
        chk(1, "an reset",  32'(an_out),  32'hF);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: read checked before the edge, registers after it.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_addr  = VECS[i].addr;
            bus_wdata = VECS[i].wdata;
            bus_wr_en = VECS[i].we;
            sw_in     = VECS[i].sw;
            btn_in    = VECS[i].btn;
            #1;
            chk(int'(VECS[i].req), $sformatf("vec %0d rdata", i), bus_rdata, VECS[i].e_rd);
            @(posedge clk);
            #1;
            chk(int'(VECS[i].req), $sformatf("vec %0d led", i), 32'(led_out), 32'(VECS[i].e_led));
            chk(int'(VECS[i].req), $sformatf("vec %0d seg", i), 32'(seg_out), 32'(VECS[i].e_seg));
            chk(int'(VECS[i].req), $sformatf("vec %0d an", i),  32'(an_out),  32'(VECS[i].e_an));
        end

        // R11: one address serves as LED output and switch input together.
        @(negedge clk);
        bus_addr  = 32'h1100_0020;
        bus_wdata = 32'h0000_7777;
        bus_wr_en = 1'b1;
        sw_in     = 16'h1111;
        #1;
        chk(11, "shared read before edge", rdata2, 32'h0000_1111);
        chk(10, "output-only port reads zero", bus_rdata, 32'h0);  // R10
        @(posedge clk);
        #1;
        chk(11, "shared led loaded", 32'(led2), 32'h7777);
        chk(11, "shared read after edge", rdata2, 32'h0000_1111);
        chk(2,  "led loaded on main instance", 32'(led_out), 32'h7777);

        // R1: reset mid-run returns every register to its reset value.
        @(negedge clk);
        bus_wr_en = 1'b0;
        rst_n     = 1'b0;
        @(posedge clk);
        #1;
        chk(1, "led mid-run reset", 32'(led_out), 32'h0000);
        chk(1, "seg mid-run reset", 32'(seg_out), 32'hFF);
        chk(1, "an mid-run reset",  32'(an_out),  32'hF);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule